// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block moves data between a word-addressed memory and a peripheral FIFO. Software first writes a memory address where a chain of descriptors starts. It then chooses a transfer direction and sets a run bit. Each descriptor takes 16 bytes of memory. The engine reads its flags word, its buffer address and its link address. It moves the byte count of the descriptor as whole 32-bit words, rounded up. It then follows the link until it finishes a descriptor that carries the last-in-chain flag.

When the chain ends, or when an error is detected, the run bit clears by itself. The channel reports a 4-bit outcome code and sets a sticky interrupt flag. A soft reset stops any work in progress and does not raise an interrupt. The memory port has one request at a time. The request is held until the memory acknowledges it, and the read data and error flag are returned with that acknowledge. The peripheral side has a valid/ready output stream (memory to peripheral) and a valid/ready input stream (peripheral to memory).

Top module: `chain_dma`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `memReq`, `txValid` and `rxReady` are all low.
- R2: Register map, with byte offsets on `regAddr` and combinational reads:
  - 0x00 global control: bit 0 is the engine enable. Writing bit 8 requests a soft reset, and bit 8 always reads 0.
  - 0x04 interrupt enable: bit 0.
  - 0x08 interrupt flag: bit 0. Writing 1 clears it.
  - 0x0C first-descriptor address.
  - 0x10 channel control: bit 7 run, bit 22 direction (1 = peripheral to memory, 0 = memory to peripheral), bits 3:0 outcome code (read only).
- R3: A write that sets run while the enable bit is clear leaves run at 0 and issues no memory request.
- R4: For a descriptor at address P, the engine reads P, then P+4, then P+8. These words are the flags (bits 15:0 byte count, bit 30 format marker, bit 31 last-in-chain), the buffer address and the link address. The word at P+12 is never read. Each request is held with a stable address until it is acknowledged.
- R5: With direction 0, the engine reads ceil(count/4) words from consecutive buffer addresses. It presents each word on the tx stream in order, holding it stable until it is accepted.
- R6: With direction 1, the engine takes ceil(count/4) words from the rx stream. It writes them in order to consecutive buffer addresses.
- R7: After a descriptor whose bit 31 is clear, the next descriptor is fetched from its link address. A chain that completes normally reports outcome code 0xF.
- R8: A descriptor whose bit 30 is clear ends the chain with code 3, and no data is moved.
- R9: An error response to a descriptor read ends the chain with code 3. An error response to a buffer read or write ends it with code 4.
- R10: A correctly formatted descriptor with a byte count of zero ends the chain with code 5.
- R11: When a chain ends, run clears and the interrupt flag sets. `irq` is high exactly while both the flag and the interrupt enable are 1.
- R12: A soft reset returns every register to zero, stops memory and stream activity at once, and leaves the interrupt flag clear.
- R13: While run is set, writes to global control (other than a soft reset), to the descriptor address and to channel control have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWData | input | 32 | Register write data |
| regRData | output | 32 | Register read data for `regAddr` |
| irq | output | 1 | Interrupt request |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | 32 | Memory byte address |
| memWData | output | 32 | Memory write data |
| memAck | input | 1 | Memory acknowledge |
| memErr | input | 1 | Error response, valid with `memAck` |
| memRData | input | 32 | Read data, valid with `memAck` |
| txValid | output | 1 | Word offered to the peripheral |
| txData | output | 32 | Word to the peripheral |
| txReady | input | 1 | Peripheral accepts the word |
| rxValid | input | 1 | Peripheral offers a word |
| rxData | input | 32 | Word from the peripheral |
| rxReady | output | 1 | Engine accepts the peripheral word |

## Verification
Random chains of one to three descriptors are built at scattered addresses, with byte counts from 1 to 16, in both directions. Memory latency and stream backpressure are random. These runs show whether the link is followed rather than the next sequential slot, whether partial words are rounded up, and whether data order survives stalls. Directed chains then cover a missing format marker, a zero count, and error responses injected on a descriptor word and on a buffer word. These separate the three failure codes and show where the engine stops. A channel stalled on an empty rx stream is used to show that writes made while busy are ignored, and that a soft reset aborts the chain without an interrupt.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;

  localparam logic [7:0] OFS_GLOBAL = 8'h00;
  localparam logic [7:0] OFS_IEN    = 8'h04;
  localparam logic [7:0] OFS_ISTS   = 8'h08;
  localparam logic [7:0] OFS_DPTR   = 8'h0C;
  localparam logic [7:0] OFS_CHAN   = 8'h10;

  localparam int GLB_EN_BIT   = 0;
  localparam int GLB_RST_BIT  = 8;
  localparam int CHAN_RUN_BIT = 7;
  localparam int CHAN_DIR_BIT = 22;
  localparam int DESC_FMT_BIT = 30;
  localparam int DESC_END_BIT = 31;

  typedef enum logic [3:0] {
    EVT_NONE      = 4'h0,
    EVT_UNDERRUN  = 4'h1,
    EVT_OVERRUN   = 4'h2,
    EVT_DESC_ERR  = 4'h3,
    EVT_DATA_ERR  = 4'h4,
    EVT_EARLY_END = 4'h5,
    EVT_OK        = 4'hF
  } evtCode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_MRD, ST_PUSH, ST_POP, ST_MWR, ST_NEXT
  } dmaState_e;

  typedef struct packed {
    logic       loadPtr;
    logic       followBranch;
    logic       selFetch;
    logic [1:0] fetchIdx;
    logic       capFlags;
    logic       capBuf;
    logic       capBranch;
    logic       capMem;
    logic       capRx;
    logic       stepWord;
  } dpStrobe_t;

endpackage

// File: rtl/chain_dma_dpath.sv
module chain_dma_dpath
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] descPtr,
  input  logic [31:0]       memRData,
  input  logic [31:0]       rxData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       dataOut,
  output logic              descFmt,
  output logic              descEnd,
  output logic              descZero,
  output logic              lastWord
);

  logic [ADDR_W-1:0] curPtr, bufPtr, linkPtr;
  logic [CNT_W-1:0]  wordsLeft, wordsInit;
  logic [31:0]       dataQ;
  logic              fmtQ, endQ, zeroQ;

  // ceil(count/4): whole words plus one when a partial word remains
  assign wordsInit = {1'b0, memRData[CNT_W-1:2]} + CNT_W'(|memRData[1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPtr    <= '0;
      bufPtr    <= '0;
      linkPtr   <= '0;
      wordsLeft <= '0;
      dataQ     <= '0;
      fmtQ      <= 1'b0;
      endQ      <= 1'b0;
      zeroQ     <= 1'b0;
    end else begin
      if (strb.loadPtr)      curPtr <= descPtr;
      if (strb.followBranch) curPtr <= linkPtr;
      if (strb.capFlags) begin
        fmtQ      <= memRData[DESC_FMT_BIT];
        endQ      <= memRData[DESC_END_BIT];
        zeroQ     <= (memRData[CNT_W-1:0] == '0);
        wordsLeft <= wordsInit;
      end
      if (strb.capBuf)    bufPtr  <= memRData[ADDR_W-1:0];
      if (strb.capBranch) linkPtr <= memRData[ADDR_W-1:0];
      if (strb.capMem)    dataQ   <= memRData;
      if (strb.capRx)     dataQ   <= rxData;
      if (strb.stepWord) begin
        bufPtr    <= bufPtr + ADDR_W'(4);
        wordsLeft <= wordsLeft - CNT_W'(1);
      end
    end
  end

  assign memAddr  = strb.selFetch ? curPtr + ADDR_W'({strb.fetchIdx, 2'b00}) : bufPtr;
  assign dataOut  = dataQ;
  assign descFmt  = fmtQ;
  assign descEnd  = endQ;
  assign descZero = zeroQ;
  assign lastWord = (wordsLeft == CNT_W'(1));

endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWData,
  output logic [31:0]       regRData,
  output logic              irq,
  output logic              memReq,
  output logic              memWe,
  input  logic              memAck,
  input  logic              memErr,
  output logic              txValid,
  input  logic              txReady,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic              descFmt,
  input  logic              descEnd,
  input  logic              descZero,
  input  logic              lastWord,
  output dpStrobe_t         strb,
  output logic [ADDR_W-1:0] descPtr
);

  dmaState_e         stateQ, stateD;
  logic [1:0]        idxQ, idxD;
  logic              enableQ, intEnQ, intStsQ, runQ, dirQ;
  evtCode_e          evtQ;
  logic [ADDR_W-1:0] descPtrQ;
  logic              finish;
  evtCode_e          finishCode;
  logic              softRst, hitGlobal, hitIen, hitIsts, hitDptr, hitChan;

  assign hitGlobal = (regAddr == REG_AW'(OFS_GLOBAL));
  assign hitIen    = (regAddr == REG_AW'(OFS_IEN));
  assign hitIsts   = (regAddr == REG_AW'(OFS_ISTS));
  assign hitDptr   = (regAddr == REG_AW'(OFS_DPTR));
  assign hitChan   = (regAddr == REG_AW'(OFS_CHAN));
  assign softRst   = regWe && hitGlobal && regWData[GLB_RST_BIT];

  // Sequencer: descriptor walk and word movement
  always_comb begin
    stateD        = stateQ;
    idxD          = idxQ;
    strb          = '0;
    strb.fetchIdx = idxQ;
    finish        = 1'b0;
    finishCode    = EVT_NONE;
    memReq        = 1'b0;
    memWe         = 1'b0;
    txValid       = 1'b0;
    rxReady       = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (runQ) begin
        strb.loadPtr = 1'b1;
        idxD         = 2'd0;
        stateD       = ST_FETCH;
      end
      ST_FETCH: begin
        memReq        = 1'b1;
        strb.selFetch = 1'b1;
        if (memAck) begin
          if (memErr) begin
            finish     = 1'b1;
            finishCode = EVT_DESC_ERR;
          end else begin
            strb.capFlags  = (idxQ == 2'd0);
            strb.capBuf    = (idxQ == 2'd1);
            strb.capBranch = (idxQ == 2'd2);
            if (idxQ == 2'd2) stateD = ST_CHECK;
            else              idxD   = idxQ + 2'd1;
          end
        end
      end
      ST_CHECK: begin
        if (!descFmt) begin
          finish     = 1'b1;
          finishCode = EVT_DESC_ERR;
        end else if (descZero) begin
          finish     = 1'b1;
          finishCode = EVT_EARLY_END;
        end else begin
          stateD = dirQ ? ST_POP : ST_MRD;
        end
      end
      ST_MRD: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            finish     = 1'b1;
            finishCode = EVT_DATA_ERR;
          end else begin
            strb.capMem = 1'b1;
            stateD      = ST_PUSH;
          end
        end
      end
      ST_PUSH: begin
        txValid = 1'b1;
        if (txReady) begin
          strb.stepWord = 1'b1;
          stateD        = lastWord ? ST_NEXT : ST_MRD;
        end
      end
      ST_POP: begin
        rxReady = 1'b1;
        if (rxValid) begin
          strb.capRx = 1'b1;
          stateD     = ST_MWR;
        end
      end
      ST_MWR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          if (memErr) begin
            finish     = 1'b1;
            finishCode = EVT_DATA_ERR;
          end else begin
            strb.stepWord = 1'b1;
            stateD        = lastWord ? ST_NEXT : ST_POP;
          end
        end
      end
      ST_NEXT: begin
        if (descEnd) begin
          finish     = 1'b1;
          finishCode = EVT_OK;
        end else begin
          strb.followBranch = 1'b1;
          idxD              = 2'd0;
          stateD            = ST_FETCH;
        end
      end
      default: stateD = ST_IDLE;
    endcase
    if (finish) stateD = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= 2'd0;
    end else if (softRst) begin
      stateQ <= ST_IDLE;
      idxQ   <= 2'd0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
    end
  end

  // Software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      intEnQ   <= 1'b0;
      intStsQ  <= 1'b0;
      runQ     <= 1'b0;
      dirQ     <= 1'b0;
      evtQ     <= EVT_NONE;
      descPtrQ <= '0;
    end else if (softRst) begin
      enableQ  <= 1'b0;
      intEnQ   <= 1'b0;
      intStsQ  <= 1'b0;
      runQ     <= 1'b0;
      dirQ     <= 1'b0;
      evtQ     <= EVT_NONE;
      descPtrQ <= '0;
    end else begin
      if (finish) begin
        runQ    <= 1'b0;
        evtQ    <= finishCode;
        intStsQ <= 1'b1;
      end else if (regWe && hitIsts && regWData[0]) begin
        intStsQ <= 1'b0;
      end
      if (regWe && hitIen) intEnQ <= regWData[0];
      if (regWe && !runQ) begin
        if (hitGlobal) enableQ  <= regWData[GLB_EN_BIT];
        if (hitDptr)   descPtrQ <= regWData[ADDR_W-1:0];
        if (hitChan) begin
          dirQ <= regWData[CHAN_DIR_BIT];
          evtQ <= EVT_NONE;
          runQ <= regWData[CHAN_RUN_BIT] && enableQ;
        end
      end
    end
  end

  always_comb begin
    regRData = '0;
    if (hitGlobal) regRData[GLB_EN_BIT] = enableQ;
    if (hitIen)    regRData[0] = intEnQ;
    if (hitIsts)   regRData[0] = intStsQ;
    if (hitDptr)   regRData = 32'(descPtrQ);
    if (hitChan) begin
      regRData[CHAN_DIR_BIT] = dirQ;
      regRData[CHAN_RUN_BIT] = runQ;
      regRData[3:0]          = evtQ;
    end
  end

  assign irq     = intStsQ && intEnQ;
  assign descPtr = descPtrQ;

  assert_run_needs_enable_R3: assert property (@(posedge clk) disable iff (!rstN)
    runQ |-> enableQ);

  assert_end_sets_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intStsQ) |-> (!runQ && $past(runQ)));

  assert_soft_reset_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (stateQ == ST_IDLE && !runQ && !intStsQ && !enableQ));

  assert_busy_write_ignored_R13: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && regWe && !softRst && !finish) |=> ($stable(dirQ) && $stable(descPtrQ) && enableQ));

endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWData,
  output logic [31:0]       regRData,
  output logic              irq,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWData,
  input  logic              memAck,
  input  logic              memErr,
  input  logic [31:0]       memRData,
  output logic              txValid,
  output logic [31:0]       txData,
  input  logic              txReady,
  input  logic              rxValid,
  input  logic [31:0]       rxData,
  output logic              rxReady
);

  dpStrobe_t         strb;
  logic [ADDR_W-1:0] descPtr;
  logic [31:0]       dataWord;
  logic              descFmt, descEnd, descZero, lastWord;
  logic              softRstReq;

  chain_dma_ctrl #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regWe(regWe), .regAddr(regAddr), .regWData(regWData), .regRData(regRData),
    .irq(irq),
    .memReq(memReq), .memWe(memWe), .memAck(memAck), .memErr(memErr),
    .txValid(txValid), .txReady(txReady), .rxValid(rxValid), .rxReady(rxReady),
    .descFmt(descFmt), .descEnd(descEnd), .descZero(descZero), .lastWord(lastWord),
    .strb(strb), .descPtr(descPtr)
  );

  chain_dma_dpath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .descPtr(descPtr),
    .memRData(memRData), .rxData(rxData), .memAddr(memAddr), .dataOut(dataWord),
    .descFmt(descFmt), .descEnd(descEnd), .descZero(descZero), .lastWord(lastWord)
  );

  assign memWData = dataWord;
  assign txData   = dataWord;

  assign softRstReq = regWe && (regAddr == REG_AW'(OFS_GLOBAL)) && regWData[GLB_RST_BIT];

  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !softRstReq) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !softRstReq) |=> (txValid && $stable(txData)));

endmodule

// File: tb/tb_chain_dma.sv
`timescale 1ns/1ps
module tb_chain_dma;

  logic        clk = 1'b0;
  logic        rstN, regWe, irq, memReq, memWe, memAck, memErr;
  logic        txValid, txReady, rxValid, rxReady;
  logic [7:0]  regAddr;
  logic [31:0] regWData, regRData, memAddr, memWData, memRData, txData, rxData;

  int          checks = 0;
  int          errors = 0;
  int          reqCount = 0;
  int          memWait = 0;
  logic [31:0] errAddr = 32'hFFFF_FFFF;
  logic [31:0] mem [256];
  logic [31:0] txLog[$];
  logic [31:0] rxQ[$];
  logic [32:0] accLog[$];

  always #2.5 clk = ~clk;

  chain_dma dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWData(regWData),
    .regRData(regRData), .irq(irq), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .memAck(memAck), .memErr(memErr), .memRData(memRData),
    .txValid(txValid), .txData(txData), .txReady(txReady), .rxValid(rxValid),
    .rxData(rxData), .rxReady(rxReady)
  );

  // Memory and peripheral models, all driven away from the active edge
  always @(negedge clk) begin
    memAck = 1'b0;
    memErr = 1'b0;
    if (memReq) begin
      reqCount++;
      if (memWait == 0) begin
        memAck = 1'b1;
        accLog.push_back({memWe, memAddr});
        if (memAddr == errAddr) memErr = 1'b1;
        else if (memWe) mem[memAddr[9:2]] = memWData;
        memRData = mem[memAddr[9:2]];
        memWait  = int'($urandom % 3);
      end else begin
        memWait--;
      end
    end
    txReady = ($urandom % 4) != 0;
    if (txValid && txReady) txLog.push_back(txData);
    rxValid = (rxQ.size() > 0) && (($urandom % 4) != 0);
    rxData  = rxValid ? rxQ[0] : 32'h0;
    if (rxValid && rxReady) void'(rxQ.pop_front());
  end

  function automatic int wordsFor(input int bytes);
    return (bytes + 3) / 4;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWe = 1'b0; regWData = 32'h0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRData;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      regRead(8'h10, v);
      if (!v[7]) break;
    end
  endtask

  task automatic clearFlag();
    regWrite(8'h08, 32'h1);
  endtask

  task automatic runChain(input bit dir, input int n);
    int          slot[3];
    int          cnt[3];
    logic [31:0] bufA[3];
    logic [31:0] expTx[$];
    logic [31:0] expWr[$];
    logic [32:0] expLog[$];
    logic [31:0] v, a;
    int          bufNext = 'h100;
    int          w, k, bad;
    slot[0] = int'($urandom % 16);
    for (int i = 1; i < n; i++) slot[i] = (slot[i-1] + 1 + int'($urandom % 5)) % 16;
    txLog.delete(); accLog.delete(); rxQ.delete();
    for (int i = 0; i < n; i++) begin
      cnt[i]  = 1 + int'($urandom % 16);
      bufA[i] = 32'(bufNext);
      w       = wordsFor(cnt[i]);
      bufNext += w * 4;
      mem[slot[i]*4]   = 32'h4000_0000 | 32'(cnt[i]) | ((i == n-1) ? 32'h8000_0000 : 32'h0);
      mem[slot[i]*4+1] = bufA[i];
      mem[slot[i]*4+2] = (i < n-1) ? 32'(slot[i+1]*16) : 32'h3F0;
      mem[slot[i]*4+3] = $urandom;
      for (int j = 0; j < 3; j++) expLog.push_back({1'b0, 32'(slot[i]*16 + j*4)});
      for (int j = 0; j < w; j++) begin
        a = bufA[i] + 32'(j*4);
        if (!dir) begin
          mem[a[9:2]] = $urandom;
          expTx.push_back(mem[a[9:2]]);
          expLog.push_back({1'b0, a});
        end else begin
          mem[a[9:2]] = 32'h0;
          expWr.push_back($urandom);
          rxQ.push_back(expWr[expWr.size()-1]);
          expLog.push_back({1'b1, a});
        end
      end
    end
    regWrite(8'h0C, 32'(slot[0]*16));
    regWrite(8'h10, {9'd0, dir, 22'h80});
    waitIdle();
    regRead(8'h10, v);
    check("R7 chain outcome code", 64'(v[3:0]), 64'hF);
    check("R11 run cleared at end", 64'(v[7]), 64'h0);
    regRead(8'h08, v);
    check("R11 flag set at end", 64'(v[0]), 64'h1);
    check("R11 irq with enable", 64'(irq), 64'h1);
    bad = (accLog.size() != expLog.size()) ? 1 : 0;
    for (int i = 0; i < expLog.size() && i < accLog.size(); i++)
      if (accLog[i] !== expLog[i]) bad = 1;
    check("R4 memory access sequence", 64'(bad), 64'h0);
    if (!dir) begin
      bad = (txLog.size() != expTx.size()) ? 1 : 0;
      for (int i = 0; i < expTx.size() && i < txLog.size(); i++)
        if (txLog[i] !== expTx[i]) bad = 1;
      check("R5 tx words and order", 64'(bad), 64'h0);
    end else begin
      bad = 0;
      k   = 0;
      for (int i = 0; i < n; i++)
        for (int j = 0; j < wordsFor(cnt[i]); j++) begin
          a = bufA[i] + 32'(j*4);
          if (mem[a[9:2]] !== expWr[k]) bad = 1;
          k++;
        end
      check("R6 rx words written to memory", 64'(bad), 64'h0);
    end
    clearFlag();
  endtask

  task automatic singleDesc(input logic [31:0] flags, input bit dir, input logic [3:0] expCode,
                            input int expTxWords, input string tag);
    logic [31:0] v;
    txLog.delete(); accLog.delete(); rxQ.delete();
    mem[0] = flags; mem[1] = 32'h200; mem[2] = 32'h3F0;
    for (int i = 0; i < 4; i++) mem[128 + i] = 32'hA500_0000 + 32'(i);
    regWrite(8'h0C, 32'h0);
    regWrite(8'h10, {9'd0, dir, 22'h80});
    waitIdle();
    regRead(8'h10, v);
    check({tag, " code"}, 64'(v[3:0]), 64'(expCode));
    check({tag, " tx words"}, 64'(txLog.size()), 64'(expTxWords));
    regRead(8'h08, v);
    check({tag, " flag"}, 64'(v[0]), 64'h1);
    clearFlag();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int          r0;
    void'($urandom(32'd20240611));
    rstN = 1'b0; regWe = 1'b0; regAddr = 8'h0; regWData = 32'h0;
    memAck = 1'b0; memErr = 1'b0; memRData = 32'h0;
    txReady = 1'b0; rxValid = 1'b0; rxData = 32'h0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      regRead(8'(i*4), v);
      check("R1 register reset value", 64'(v), 64'h0);
    end
    check("R1 outputs idle", 64'({irq, memReq, txValid, rxReady}), 64'h0);

    // R2 map readback, R3 run refused while disabled
    regWrite(8'h04, 32'h1);
    regRead(8'h04, v);
    check("R2 interrupt enable readback", 64'(v), 64'h1);
    regWrite(8'h0C, 32'h0000_0123);
    regRead(8'h0C, v);
    check("R2 descriptor address readback", 64'(v), 64'h123);
    r0 = reqCount;
    regWrite(8'h10, 32'h0040_0080);
    repeat (10) @(negedge clk);
    regRead(8'h10, v);
    check("R3 run stays clear when disabled", 64'(v[7]), 64'h0);
    check("R2 direction bit readback", 64'(v[22]), 64'h1);
    check("R3 no memory request", 64'(reqCount - r0), 64'h0);
    regWrite(8'h00, 32'h1);
    regRead(8'h00, v);
    check("R2 enable readback", 64'(v), 64'h1);

    // Random chains, both directions
    for (int t = 0; t < 10; t++) runChain(t[0], 1 + int'($urandom % 3));
    runChain(1'b0, 3);
    runChain(1'b1, 3);

    // R8 missing format marker, R10 zero count
    singleDesc(32'h8000_0004, 1'b0, 4'h3, 0, "R8 format clear");
    singleDesc(32'hC000_0000, 1'b0, 4'h5, 0, "R10 zero count");
    // R9 error on descriptor word, then on second buffer word
    errAddr = 32'h4;
    singleDesc(32'hC000_000C, 1'b0, 4'h3, 0, "R9 descriptor error");
    errAddr = 32'h204;
    singleDesc(32'hC000_000C, 1'b0, 4'h4, 1, "R9 data error");
    errAddr = 32'hFFFF_FFFF;

    // R11 flag gating and write-one-to-clear
    singleDesc(32'hC000_0004, 1'b0, 4'hF, 1, "R11 single word");
    regWrite(8'h04, 32'h0);
    singleDesc(32'hC000_0004, 1'b0, 4'hF, 1, "R11 masked run");
    check("R11 irq masked", 64'(irq), 64'h0);
    regWrite(8'h04, 32'h1);
    regRead(8'h08, v);
    check("R11 flag cleared by write of one", 64'(v), 64'h0);
    check("R11 irq low after clear", 64'(irq), 64'h0);

    // R13 writes while busy: channel stalls waiting for rx data
    rxQ.delete();
    mem[0] = 32'hC000_0008; mem[1] = 32'h200; mem[2] = 32'h3F0;
    regWrite(8'h0C, 32'h0);
    regWrite(8'h10, 32'h0040_0080);
    repeat (30) @(negedge clk);
    regWrite(8'h10, 32'h0);
    regWrite(8'h00, 32'h0);
    regWrite(8'h0C, 32'h40);
    regRead(8'h10, v);
    check("R13 run and direction unchanged", 64'({v[22], v[7]}), 64'h3);
    regRead(8'h00, v);
    check("R13 enable unchanged", 64'(v), 64'h1);
    regRead(8'h0C, v);
    check("R13 descriptor address unchanged", 64'(v), 64'h0);
    check("R13 still waiting on rx", 64'(rxReady), 64'h1);

    // R12 soft reset aborts the stalled chain
    regWrite(8'h00, 32'h100);
    repeat (20) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      regRead(8'(i*4), v);
      check("R12 register cleared", 64'(v), 64'h0);
    end
    check("R12 activity stopped, no irq", 64'({irq, memReq, txValid, rxReady}), 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule